// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches three modem status lines: data-set-ready (DSR), carrier-detect (CD) and clear-to-send (CTS). Each line is brought into the core clock domain through its own synchronizer. Software can enable detection per line and per direction, so a falling edge, a rising edge, or both can mark the line as changed. A detected change sets a sticky flag in a change-status word. The current synchronized levels are also presented in a separate level word.

Whenever any flag is set and the modem interrupt enable is on, the block raises an interrupt request. The host services the request by reading the change word. It then pulses an end-of-interrupt strobe, which clears every flag at once. A change that is detected in the same cycle as the strobe is not lost.

The block has no data stream, so there is no valid/ready interface and no back-pressure. All pins are plain control and status pins.

Top module: `modem_change_det`

## Requirements
- R1: While `rst_n` is low, `level_word`, `change_word` and `irq` are all zero. Every synchronizer and history stage also resets low, so an input that is high when reset is released is seen as a rising edge.
- R2: `level_word` bits 7, 6 and 5 carry the synchronized levels of DSR, CD and CTS. Each bit follows its input two clock edges after the input changes.
- R3: A 1-to-0 change on a line whose bit is set in `fall_en` sets the matching `change_word` bit (7 = DSR, 6 = CD, 5 = CTS). The flag is visible one clock edge after the level bit changes. In `fall_en`, bit 2 = DSR, bit 1 = CD and bit 0 = CTS.
- R4: A 0-to-1 change on a line whose bit is set in `rise_en` sets the matching `change_word` bit with the same timing as R3. `rise_en` uses the same bit order as `fall_en`.
- R5: A change in a direction whose enable is clear never sets a flag.
- R6: A set flag stays set until `eoi` is sampled high. `eoi` clears all three flags together.
- R7: A change detected in the same cycle as `eoi` leaves its flag set after the clear.
- R8: `irq` is high exactly when at least one `change_word` flag is set and `irq_en` is high.
- R9: `level_word` bits 4:0 and `change_word` bits 4:0 always read zero.
- R10: A change on one line sets only that line's flag and leaves the other two flags untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| cd_in | input | 1 | Carrier-detect line, asynchronous |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| fall_en | input | 3 | Per-line falling-edge enables (2 = DSR, 1 = CD, 0 = CTS) |
| rise_en | input | 3 | Per-line rising-edge enables (same bit order) |
| irq_en | input | 1 | Modem interrupt enable |
| eoi | input | 1 | End-of-interrupt strobe; clears all change flags |
| level_word | output | 8 | Synchronized levels in bits 7:5 |
| change_word | output | 8 | Sticky change flags in bits 7:5 |
| irq | output | 1 | Modem change interrupt request |

## Verification
Faults in the synchronizer or the history register show up at the ports within three clock edges of an input change. A stage lost or added in the synchronizer shifts `level_word` by a cycle. A history register that is stuck or mis-reset makes a flag appear with no edge, or never appear. Faults in the sticky bank show up when the host acts on it. A flag that decays without `eoi`, survives `eoi`, or drops a change that coincided with `eoi` is visible one edge after the strobe. A wrong direction or line mapping sets the wrong bit of `change_word` on the first edge of the affected line.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  // number of watched modem lines: index 2 = DSR, 1 = CD, 0 = CTS
  localparam int unsigned SIG_N       = 3;
  // width of the host-visible status words
  localparam int unsigned WORD_W      = 8;
  // bit of the status words that holds the CTS entry; CD and DSR follow upward
  localparam int unsigned SIG_LSB     = 5;
  // flops in each input synchronizer
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mcd_edge.sv
module mcd_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] rise_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= level;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      logic went_up, went_down;
      assign went_up   =  level[i] & ~hist_q[i];
      assign went_down = ~level[i] &  hist_q[i];
      assign hit[i]    = (went_up & rise_en[i]) | (went_down & fall_en[i]);
    end
  endgenerate
endmodule

// File: rtl/mcd_flags.sv
module mcd_flags #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic         clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] flag_q;

  // clear first, then merge new hits so a coincident hit survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (clr ? '0 : flag_q) | hit;
  end

  assign flags = flag_q;
endmodule

// File: rtl/modem_change_det.sv
module modem_change_det
  import mcd_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsr_in,
  input  logic              cd_in,
  input  logic              cts_in,
  input  logic [SIG_N-1:0]  fall_en,
  input  logic [SIG_N-1:0]  rise_en,
  input  logic              irq_en,
  input  logic              eoi,
  output logic [WORD_W-1:0] level_word,
  output logic [WORD_W-1:0] change_word,
  output logic              irq
);
  logic [SIG_N-1:0] raw_lines;
  logic [SIG_N-1:0] sync_lines;
  logic [SIG_N-1:0] edge_hit;
  logic [SIG_N-1:0] flag_bits;

  assign raw_lines = {dsr_in, cd_in, cts_in};

  mcd_sync #(.W(SIG_N), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_lines),
    .sync_out (sync_lines)
  );

  mcd_edge #(.W(SIG_N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (sync_lines),
    .fall_en (fall_en),
    .rise_en (rise_en),
    .hit     (edge_hit)
  );

  mcd_flags #(.W(SIG_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (edge_hit),
    .clr   (eoi),
    .flags (flag_bits)
  );

  always_comb begin
    level_word                    = '0;
    level_word[SIG_LSB +: SIG_N]  = sync_lines;
    change_word                   = '0;
    change_word[SIG_LSB +: SIG_N] = flag_bits;
  end

  assign irq = irq_en & (|flag_bits);
endmodule

// File: rtl/mcd_chk.sv
module mcd_chk
  import mcd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SIG_N-1:0]  fall_en,
  input logic [SIG_N-1:0]  rise_en,
  input logic              irq_en,
  input logic              eoi,
  input logic [WORD_W-1:0] level_word,
  input logic [WORD_W-1:0] change_word,
  input logic              irq
);
  logic [SIG_N-1:0] lvl, chg, lvl_prev, seen;

  assign lvl = level_word[SIG_LSB +: SIG_N];
  assign chg = change_word[SIG_LSB +: SIG_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl;
  end

  assign seen = (lvl & ~lvl_prev & rise_en) | (~lvl & lvl_prev & fall_en);

  generate
    for (genvar b = 0; b < SIG_N; b++) begin : g_bit
      assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[b] && !lvl_prev[b] && rise_en[b]) |=> chg[b]);
      assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[b] && lvl_prev[b] && fall_en[b]) |=> chg[b]);
      assert_no_stray_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg[b] && !seen[b]) |=> !chg[b]);
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg[b] && !eoi) |=> chg[b]);
      assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !seen[b]) |=> !chg[b]);
      assert_keep_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && seen[b]) |=> chg[b]);
    end
  endgenerate

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_en && (chg != '0)));
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level_word[SIG_LSB-1:0] == '0) && (change_word[SIG_LSB-1:0] == '0));
endmodule

bind modem_change_det mcd_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fall_en     (fall_en),
  .rise_en     (rise_en),
  .irq_en      (irq_en),
  .eoi         (eoi),
  .level_word  (level_word),
  .change_word (change_word),
  .irq         (irq)
);

// File: tb/modem_change_det_test.sv
module modem_change_det_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dsr_in = 1'b0, cd_in = 1'b0, cts_in = 1'b0;
  logic [2:0] fall_en = '0, rise_en = '0;
  logic       irq_en = 1'b0, eoi = 1'b0;
  logic [7:0] level_word, change_word;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modem_change_det uut (
    .clk(clk), .rst_n(rst_n), .dsr_in(dsr_in), .cd_in(cd_in), .cts_in(cts_in),
    .fall_en(fall_en), .rise_en(rise_en), .irq_en(irq_en), .eoi(eoi),
    .level_word(level_word), .change_word(change_word), .irq(irq)
  );

  // row: {lines[2:0] (DSR,CD,CTS), fall_en, rise_en, expected flags, pulse eoi}
  localparam int NROW = 10;
  localparam logic [12:0] VEC [NROW] = '{
    {3'b111, 3'b000, 3'b111, 3'b111, 1'b1},
    {3'b000, 3'b000, 3'b111, 3'b000, 1'b0},
    {3'b100, 3'b000, 3'b100, 3'b100, 1'b0},
    {3'b110, 3'b000, 3'b010, 3'b110, 1'b1},
    {3'b010, 3'b100, 3'b000, 3'b100, 1'b1},
    {3'b001, 3'b010, 3'b000, 3'b010, 1'b1},
    {3'b000, 3'b001, 3'b111, 3'b001, 1'b1},
    {3'b101, 3'b111, 3'b111, 3'b101, 1'b1},
    {3'b010, 3'b111, 3'b000, 3'b101, 1'b1},
    {3'b010, 3'b111, 3'b111, 3'b000, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1;
    settle(1);
    eoi = 1'b0;
  endtask

  initial begin
    irq_en = 1'b1;
    settle(3);
    // R1: outputs held at zero in reset
    check("R1 level", level_word, 8'h00);
    check("R1 change", change_word, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    settle(2);

    for (int i = 0; i < NROW; i++) begin
      logic [12:0] v;
      v = VEC[i];
      {dsr_in, cd_in, cts_in} = v[12:10];
      fall_en = v[9:7];
      rise_en = v[6:4];
      settle(3);
      check("R2 level", level_word, {v[12:10], 5'b0});
      check("R3/R4/R5/R10 flags", change_word, {v[3:1], 5'b0});
      check("R8 irq", {7'b0, irq}, {7'b0, |v[3:1]});
      if (v[0]) begin
        pulse_eoi();
        check("R6 clear", change_word, 8'h00);
      end
    end

    // lines now DSR=0 CD=1 CTS=0, flags clear, all enables on
    irq_en = 1'b0;
    cts_in = 1'b1;
    settle(3);
    check("R4 cts rise", change_word, 8'h20);
    check("R8 irq gated off", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    #1;
    check("R8 irq on", {7'b0, irq}, 8'h01);
    settle(6);
    check("R6 sticky hold", change_word, 8'h20);

    // R7: DSR edge detected in the cycle eoi is high
    dsr_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    eoi = 1'b1;
    settle(1);
    eoi = 1'b0;
    check("R7 coincident edge kept", change_word, 8'h80);
    pulse_eoi();
    check("R6 clear after R7", change_word, 8'h00);

    // R5: all directions disabled, every line toggles
    fall_en = 3'b000;
    rise_en = 3'b000;
    {dsr_in, cd_in, cts_in} = 3'b000;
    settle(4);
    check("R5 disabled fall", change_word, 8'h00);
    {dsr_in, cd_in, cts_in} = 3'b111;
    settle(4);
    check("R5 disabled rise", change_word, 8'h00);
    check("R9 unused level bits", {3'b0, level_word[4:0]}, 8'h00);
    check("R9 unused change bits", {3'b0, change_word[4:0]}, 8'h00);

    // R1: reset in mid-run clears set flags
    fall_en = 3'b111;
    {dsr_in, cd_in, cts_in} = 3'b000;
    settle(3);
    check("R3 all fall", change_word, 8'hE0);
    rst_n = 1'b0;
    #1;
    check("R1 reset flags", change_word, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    settle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule